// File: doc/BRIEF.md
# Lockable Rotating Bank Mapper

This block translates the low 2 MB of a 24-bit cartridge bus into physical ROM addresses. It splits that span into eight windows of 256 KB. Each window is steered to one of eight banks. The steering comes from three byte-wide configuration registers, named D, E and F. The host loads them by writing to the first 64 KB of the cartridge space.

Two arrangements are available:
- **Single bank:** every window shows the same bank.
- **Rotated:** window i shows bank (index + i) mod 8, so the full ROM appears in linear order starting at the chosen bank.

Register E carries an unlock flag. Once the host clears it, the mapper ignores every later write until the next reset. Register D drives an output that tells the storage side whether SRAM is mapped in. A read anywhere in the I/O page at 0xA13000–0xA130FF returns the upper nibble of register F, which holds the current bank index. The ROM and SRAM arrays themselves are outside this block.

Top module: `bank_rotor_mapper`

## Requirements
- R1: After reset, the registers hold D=0x00, E=0x80 and F=0x00. This means SRAM is disabled, single-bank mode is selected, the bank index is 0 and the mapper is unlocked.
- R2: A write changes a register only when bus address bits 23:16 are zero and bits 11:8 equal 0xD, 0xE or 0xF, selecting register D, E or F. Any other write leaves all registers unchanged.
- R3: While bit 7 of register E is 0, every write is ignored, including writes to E. Only reset unlocks the mapper again.
- R4: The output `sram_map_en` equals bit 7 of register D.
- R5: The bank index is bits 6:4 of register F. When bit 6 of register E is 0, every window maps to that bank.
- R6: When bit 6 of register E is 1, window i (bus address bits 20:18) maps to bank (index + i) mod 8.
- R7: When bus address bits 23:8 equal 0xA130, `io_rd_hit` is 1 and `io_rd_data` equals register F AND 0xF0. Otherwise `io_rd_hit` is 0 and `io_rd_data` is 0.
- R8: Which data byte a write uses depends on its size and address:
  - A byte write to an odd address uses data bits 7:0.
  - A byte write to an even address uses data bits 15:8.
  - A 16-bit write always uses data bits 7:0.
- R9: `phys_valid` is 1 exactly when the bus address is below 0x200000. `phys_addr` is then {window bank, bus address bits 17:0}.
- R10: A write accepted at one clock edge is visible on all outputs before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Bus write strobe, one cycle per access |
| wr_word | input | 1 | 1 for a 16-bit write, 0 for a byte write |
| bus_addr | input | 24 | Bus byte address |
| wr_data | input | 16 | Bus write data |
| phys_addr | output | 21 | Translated ROM address |
| phys_valid | output | 1 | Bus address lies in the mapped 2 MB |
| sram_map_en | output | 1 | SRAM mapping enable |
| io_rd_hit | output | 1 | Bus address lies in the readback I/O page |
| io_rd_data | output | 8 | Bank-index readback value |

## Verification
The assertions assume that `bus_addr`, `wr_en`, `wr_word` and `wr_data` are stable and known in every cycle after reset. They also assume that a write strobe lasts exactly one clock per access. The stimulus changes inputs only on the falling edge and pulses `wr_en` for a single cycle.

During the random phase, any write aimed at register E has bit 7 set in both data bytes. This keeps the mapper unlocked while the mode bit, the bank index and the SRAM enable roam freely. Locking is exercised only in a directed step near the end, followed by a reset.

// File: rtl/bank_rotor_pkg.sv
package bank_rotor_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_D    = 2'd1,
    SEL_E    = 2'd2,
    SEL_F    = 2'd3
  } reg_sel_e;

  localparam logic [3:0] CODE_D = 4'hD;
  localparam logic [3:0] CODE_E = 4'hE;
  localparam logic [3:0] CODE_F = 4'hF;

  localparam logic [7:0] RST_D = 8'h00;
  localparam logic [7:0] RST_E = 8'h80;
  localparam logic [7:0] RST_F = 8'h00;

  localparam int UNLOCK_BIT = 7;
  localparam int ROTATE_BIT = 6;
  localparam int SRAM_BIT   = 7;
  localparam int IDX_LSB    = 4;
endpackage

// File: rtl/bank_rotor_cfg.sv
module bank_rotor_cfg
  import bank_rotor_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int CFG_SPAN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [7:0]        reg_d,
  output logic [7:0]        reg_e,
  output logic [7:0]        reg_f
);
  localparam int HI_W = ADDR_W - CFG_SPAN;

  reg_sel_e   sel;
  logic       in_region;
  logic       accept;
  logic [7:0] wbyte;
  logic [7:0] d_nxt, e_nxt, f_nxt;
  logic       d_en, e_en, f_en;

  always_comb begin
    in_region = (bus_addr[ADDR_W-1:CFG_SPAN] == {HI_W{1'b0}});
    unique case (bus_addr[11:8])
      CODE_D:  sel = SEL_D;
      CODE_E:  sel = SEL_E;
      CODE_F:  sel = SEL_F;
      default: sel = SEL_NONE;
    endcase
    accept = wr_en && in_region && reg_e[UNLOCK_BIT] && (sel != SEL_NONE);
    if (wr_word || bus_addr[0]) wbyte = wr_data[7:0];
    else                        wbyte = wr_data[15:8];
    d_en  = accept && (sel == SEL_D);
    e_en  = accept && (sel == SEL_E);
    f_en  = accept && (sel == SEL_F);
    d_nxt = wbyte;
    e_nxt = wbyte;
    f_nxt = wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_d <= RST_D;
      reg_e <= RST_E;
      reg_f <= RST_F;
    end else begin
      if (d_en) reg_d <= d_nxt;
      if (e_en) reg_e <= e_nxt;
      if (f_en) reg_f <= f_nxt;
    end
  end
endmodule

// File: rtl/bank_rotor_xlat.sv
module bank_rotor_xlat #(
  parameter int ADDR_W   = 24,
  parameter int WIN_BITS = 3,
  parameter int OFS_BITS = 18
) (
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [WIN_BITS-1:0]          bank_idx,
  input  logic                         rotate,
  output logic [WIN_BITS+OFS_BITS-1:0] phys_addr,
  output logic                         phys_valid
);
  localparam int NWIN  = 1 << WIN_BITS;
  localparam int SPAN  = WIN_BITS + OFS_BITS;
  localparam int TOP_W = ADDR_W - SPAN;

  logic [WIN_BITS-1:0] win_bank [NWIN];
  logic [WIN_BITS-1:0] win_sel;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam logic [WIN_BITS-1:0] OFFS = WIN_BITS'(i);
    always_comb win_bank[i] = rotate ? (bank_idx + OFFS) : bank_idx;
  end

  always_comb begin
    win_sel    = bus_addr[SPAN-1:OFS_BITS];
    phys_addr  = {win_bank[win_sel], bus_addr[OFS_BITS-1:0]};
    phys_valid = (bus_addr[ADDR_W-1:SPAN] == {TOP_W{1'b0}});
  end
endmodule

// File: rtl/bank_rotor_iord.sv
module bank_rotor_iord #(
  parameter int          ADDR_W  = 24,
  parameter logic [15:0] IO_PAGE = 16'hA130
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        reg_f,
  output logic              io_rd_hit,
  output logic [7:0]        io_rd_data
);
  always_comb begin
    io_rd_hit  = (bus_addr[ADDR_W-1:8] == IO_PAGE);
    io_rd_data = io_rd_hit ? {reg_f[7:4], 4'h0} : 8'h00;
  end
endmodule

// File: rtl/bank_rotor_mapper.sv
module bank_rotor_mapper
  import bank_rotor_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int WIN_BITS = 3,
  parameter int OFS_BITS = 18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_word,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [WIN_BITS+OFS_BITS-1:0] phys_addr,
  output logic                         phys_valid,
  output logic                         sram_map_en,
  output logic                         io_rd_hit,
  output logic [7:0]                   io_rd_data
);
  logic [1:0] rst_sync;
  logic       rst_n_int;
  logic [7:0] cfg_d, cfg_e, cfg_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  bank_rotor_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_SPAN(16)) u_cfg (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_word(wr_word),
    .bus_addr(bus_addr), .wr_data(wr_data),
    .reg_d(cfg_d), .reg_e(cfg_e), .reg_f(cfg_f)
  );

  bank_rotor_xlat #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .OFS_BITS(OFS_BITS)) u_xlat (
    .bus_addr(bus_addr),
    .bank_idx(cfg_f[IDX_LSB +: WIN_BITS]),
    .rotate(cfg_e[ROTATE_BIT]),
    .phys_addr(phys_addr), .phys_valid(phys_valid)
  );

  bank_rotor_iord #(.ADDR_W(ADDR_W)) u_iord (
    .bus_addr(bus_addr), .reg_f(cfg_f),
    .io_rd_hit(io_rd_hit), .io_rd_data(io_rd_data)
  );

  assign sram_map_en = cfg_d[SRAM_BIT];
endmodule

// File: rtl/bank_rotor_checker.sv
module bank_rotor_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [23:0] bus_addr,
  input logic [20:0] phys_addr,
  input logic        phys_valid,
  input logic        io_rd_hit,
  input logic [7:0]  io_rd_data,
  input logic [7:0]  cfg_d,
  input logic [7:0]  cfg_e,
  input logic [7:0]  cfg_f
);
  p_outside_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr[23:16] != 8'h00) |=>
      ($stable(cfg_d) && $stable(cfg_e) && $stable(cfg_f)));

  p_locked_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_e[7]) |=> ($stable(cfg_d) && $stable(cfg_e) && $stable(cfg_f)));

  p_single_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phys_valid && !cfg_e[6]) |-> (phys_addr[20:18] == cfg_f[6:4]));

  p_rotated_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phys_valid && cfg_e[6]) |-> (phys_addr[20:18] == 3'(cfg_f[6:4] + bus_addr[20:18])));

  p_readback_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd_hit |-> (io_rd_data[3:0] == 4'h0 && io_rd_data[7:4] == cfg_f[7:4]));

  p_offset_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phys_valid |-> (phys_addr[17:0] == bus_addr[17:0]));
endmodule

bind bank_rotor_mapper bank_rotor_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_addr(bus_addr),
  .phys_addr(phys_addr), .phys_valid(phys_valid),
  .io_rd_hit(io_rd_hit), .io_rd_data(io_rd_data),
  .cfg_d(cfg_d), .cfg_e(cfg_e), .cfg_f(cfg_f)
);

// File: tb/bank_rotor_mapper_bench.sv
`timescale 1ns/1ps
module bank_rotor_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_word = 1'b0;
  logic [23:0] bus_addr = 24'h0;
  logic [15:0] wr_data = 16'h0;
  logic [20:0] phys_addr;
  logic        phys_valid, sram_map_en, io_rd_hit;
  logic [7:0]  io_rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] m_d, m_e, m_f;

  always #2.5 clk = ~clk;

  bank_rotor_mapper u_bank_rotor_mapper (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .bus_addr(bus_addr), .wr_data(wr_data), .phys_addr(phys_addr),
    .phys_valid(phys_valid), .sram_map_en(sram_map_en),
    .io_rd_hit(io_rd_hit), .io_rd_data(io_rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] exp_phys(input logic [23:0] a);
    logic [2:0] bk;
    bk = m_e[6] ? 3'(m_f[6:4] + a[20:18]) : m_f[6:4];
    return {bk, a[17:0]};
  endfunction

  task automatic model_reset();
    m_d = 8'h00; m_e = 8'h80; m_f = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  task automatic do_write(input logic [23:0] a, input logic [15:0] d, input logic w);
    logic [7:0] b;
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_word = w; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    b = (w || a[0]) ? d[7:0] : d[15:8];
    if (a[23:16] == 8'h00 && m_e[7]) begin
      case (a[11:8])
        4'hD: m_d = b;
        4'hE: m_e = b;
        4'hF: m_f = b;
        default: ;
      endcase
    end
  endtask

  task automatic probe(input logic [23:0] a, input string req);
    bus_addr = a; #1;
    chk(req, {31'b0, phys_valid}, {31'b0, (a < 24'h200000)});
    if (a < 24'h200000) chk(req, {11'b0, phys_addr}, {11'b0, exp_phys(a)});
    chk("R4", {31'b0, sram_map_en}, {31'b0, m_d[7]});
    chk("R7", {23'b0, io_rd_hit, io_rd_data},
        (a[23:8] == 16'hA130) ? {23'b0, 1'b1, m_f & 8'hF0} : 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] a;
    logic [15:0] d;
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    probe(24'hA13010, "R1");
    probe(24'h1C0004, "R1");
    chk("R1", {31'b0, sram_map_en}, 0);

    // R5 single-bank and R10 visibility after one edge
    do_write(24'h000F01, 16'h0050, 1'b0);
    #1 bus_addr = 24'h0C0123; #1;
    chk("R10", {11'b0, phys_addr}, {11'b0, 3'd5, 18'h00123});
    probe(24'h1FFFFF, "R5");
    // R6 rotation with wrap
    do_write(24'h000E00, 16'h00C0, 1'b1);
    for (int i = 0; i < 8; i++) probe({3'b0, 3'(i), 18'h2A5A5}, "R6");
    // R4
    do_write(24'h000D01, 16'h0080, 1'b0);
    probe(24'h000000, "R4");
    // R8 lanes
    do_write(24'h000F00, 16'h3050, 1'b0);
    probe(24'hA13000, "R8");
    do_write(24'h000F01, 16'h3050, 1'b0);
    probe(24'hA130FF, "R8");
    do_write(24'h000F00, 16'h6070, 1'b1);
    probe(24'hA13081, "R8");
    // R2 ignored writes: wrong code, outside region
    do_write(24'h000C01, 16'h0010, 1'b1);
    do_write(24'h010F01, 16'h0010, 1'b1);
    do_write(24'h400F01, 16'h0010, 1'b1);
    probe(24'hA13000, "R2");
    chk("R2", {24'b0, io_rd_data}, 32'h70);
    // R9 boundary
    probe(24'h200000, "R9");
    probe(24'h1FFFFF, "R9");

    // random phase
    for (int n = 0; n < 400; n++) begin
      int s;
      s = $urandom_range(0, 4);
      a = $urandom() & 24'hFFFFFF;
      if (s < 4) a[23:16] = 8'h00;
      case (s)
        0: a[11:8] = 4'hD;
        1: a[11:8] = 4'hE;
        2: a[11:8] = 4'hF;
        default: ;
      endcase
      d = 16'($urandom());
      if (a[23:16] == 8'h00 && a[11:8] == 4'hE) d = d | 16'h8080;
      do_write(a, d, 1'($urandom_range(0, 1)));
      a = $urandom() & 24'h1FFFFF;
      probe(a, "R6");
      if ($urandom_range(0, 3) == 0) probe({16'hA130, 8'($urandom())}, "R7");
    end

    // R3 lock
    do_write(24'h000F01, 16'h0020, 1'b0);
    do_write(24'h000E01, 16'h0040, 1'b1);
    do_write(24'h000F01, 16'h0070, 1'b0);
    do_write(24'h000E01, 16'h0080, 1'b1);
    do_write(24'h000D01, 16'h0080, 1'b0);
    probe(24'hA13000, "R3");
    chk("R3", {24'b0, io_rd_data}, 32'h20);
    probe(24'h040000, "R3");
    do_reset();
    probe(24'hA13000, "R1");
    do_write(24'h000F01, 16'h0030, 1'b0);
    probe(24'hA13000, "R3");
    chk("R3", {24'b0, io_rd_data}, 32'h30);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule